// File: doc/BRIEF.md
# Channel-Status Rate and Emphasis Decoder

This block sits behind the bit-level receiver of a two-channel digital audio interface. It takes the channel-status bit of each channel, one bit per enabled cycle, together with a strobe that marks the first bit of a status block. From the channel picked by the select input it keeps bytes 0, 3 and 4. After the last bit of byte 4 it derives a 4-bit sample-rate code and a pre-emphasis flag from those bytes.

Byte 0 bit 0 sets the format: 0 is consumer and 1 is professional. Consumer frames give the rate code as a straight copy of a byte-3 field. Professional frames build it from a 2-bit byte-0 rate field and a 4-bit byte-4 extension field. The emphasis pattern sits in different byte-0 bits in each format. The select input is taken when a block starts, so flipping it in the middle of a block has no effect until the next block. Both outputs are loaded together, so a reader never sees a code from one block next to a flag from another.

Top module: `cs_rate_emph_decoder`

## Requirements
- R1: While reset is asserted and after it is released, until the first complete block, `rate_code` is 4'b0001 and `emph_on` is 0.
- R2: Consumer format (byte 0 bit 0 = 0): `rate_code` equals byte 3 bits 3..0, with byte 3 bit 0 as the code LSB. Byte 4 and byte 0 bits 7..6 have no effect.
- R3: Professional format (byte 0 bit 0 = 1) with byte 4 bits 6..3 = 0000: byte 0 bits 7..6 of 01, 10 and 11 give codes 0000, 0010 and 0011, and 00 gives 0001.
- R4: Professional format with byte 0 bits 7..6 = 00: a byte 4 bits 6..3 value of 1010 gives code 1000, 0010 gives code 1010, and any other value gives 0001. Any non-zero extension while byte 0 bits 7..6 are not 00 gives 0001.
- R5: Professional format: `emph_on` is 1 only when byte 0 bit 2 = 1, bit 3 = 0 and bit 4 = 0.
- R6: Consumer format: `emph_on` is 1 only when byte 0 bit 3 = 1, bit 4 = 0 and bit 5 = 0.
- R7: The channel is chosen by `ch_sel` as sampled with the block-start bit: 0 picks `cs_bit_ch1` and 1 picks `cs_bit_ch2`. Changes of `ch_sel` later in the block are ignored.
- R8: Bits are taken LSB-first per byte. Bit 39 (byte 4 bit 7) is sampled at one clock edge, and both outputs change together at the following edge. They hold their values at all other times, including during and after a block that is cut short.
- R9: A cycle with `bit_en` = 0 consumes no bit, and `blk_start` is ignored in that cycle.
- R10: `blk_start` with `bit_en` = 1 restarts capture at bit 0 of byte 0, even in the middle of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | A channel-status bit is present this cycle |
| blk_start | input | 1 | This bit is bit 0 of byte 0 of a block |
| cs_bit_ch1 | input | 1 | Channel-status bit of channel 1 |
| cs_bit_ch2 | input | 1 | Channel-status bit of channel 2 |
| ch_sel | input | 1 | Channel select, 0 = channel 1, 1 = channel 2 |
| rate_code | output | 4 | Decoded sample-rate code |
| emph_on | output | 1 | Pre-emphasis detected |

## Verification
The bench runs all 16 consumer rate fields against every value of the byte-0 emphasis field, and all 64 pairs of professional rate field and extension. A swapped mapping entry or an off-by-one bit position in either emphasis pattern therefore shows up as a wrong code or flag. It drives different data on the two channels and flips the select in the middle of a block: a design that follows the live select instead of the one taken at block start would decode the wrong channel. It inserts idle cycles that carry junk data and spurious start strobes, restarts a block partway through, and checks the exact edge at which the outputs move. A design that counted idle bits, ignored restarts or loaded the outputs one cycle early or late would fail these checks.

// File: rtl/cs_rate_pkg.sv
package cs_rate_pkg;

   localparam int CS_BYTE_W   = 8;
   localparam int CS_RATE_W   = 4;
   localparam int CS_LAST_BYTE = 4;
   localparam int CS_NCAP     = 3;

   localparam logic [CS_RATE_W-1:0] RATE_44K1 = 4'b0000;
   localparam logic [CS_RATE_W-1:0] RATE_NONE = 4'b0001;
   localparam logic [CS_RATE_W-1:0] RATE_48K  = 4'b0010;
   localparam logic [CS_RATE_W-1:0] RATE_32K  = 4'b0011;
   localparam logic [CS_RATE_W-1:0] RATE_88K2 = 4'b1000;
   localparam logic [CS_RATE_W-1:0] RATE_96K  = 4'b1010;

   typedef enum logic {
      FMT_CONSUMER = 1'b0,
      FMT_PRO      = 1'b1
   } cs_fmt_e;

   // slot k of the capture store holds this byte of the block
   function automatic int cap_byte_index(input int slot);
      case (slot)
         0:       return 0;
         1:       return 3;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/cs_stream_capture.sv
module cs_stream_capture
   import cs_rate_pkg::*;
#(
   parameter int BYTE_W    = CS_BYTE_W,
   parameter int LAST_BYTE = CS_LAST_BYTE,
   parameter int NCAP      = CS_NCAP
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bit_en,
   input  logic                     blk_start,
   input  logic                     bit_ch1,
   input  logic                     bit_ch2,
   input  logic                     ch_sel,
   output logic [NCAP*BYTE_W-1:0]   cap_flat,
   output logic                     cap_done
);

   localparam int TOTAL_BITS = (LAST_BYTE + 1) * BYTE_W;
   localparam int CNT_W      = $clog2(TOTAL_BITS + 1);
   localparam int POS_W      = $clog2(BYTE_W);
   localparam int BN_W       = CNT_W - POS_W;
   localparam logic [CNT_W-1:0] IDLE_CNT = CNT_W'(TOTAL_BITS);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TOTAL_BITS - 1);

   generate
      if ((1 << POS_W) != BYTE_W) begin : g_chk_pow2
         $error("cs_stream_capture: BYTE_W must be a power of two");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] idx;
   logic             sel_q;
   logic             sel_now;
   logic             in_block;
   logic             take;
   logic             cur_bit;

   assign in_block = (cnt_q != IDLE_CNT);
   assign take     = bit_en & (blk_start | in_block);
   assign idx      = blk_start ? '0 : cnt_q;
   assign sel_now  = blk_start ? ch_sel : sel_q;
   assign cur_bit  = sel_now ? bit_ch2 : bit_ch1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= IDLE_CNT;
         sel_q    <= 1'b0;
         cap_done <= 1'b0;
      end else begin
         if (take) begin
            cnt_q <= idx + CNT_W'(1);
         end
         if (bit_en && blk_start) begin
            sel_q <= ch_sel;
         end
         cap_done <= take && (idx == LAST_CNT);
      end
   end

   genvar k;
   generate
      for (k = 0; k < NCAP; k++) begin : g_slot
         localparam logic [BN_W-1:0] BYTE_NUM = BN_W'(cap_byte_index(k));
         logic [BYTE_W-1:0] byte_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               byte_q <= '0;
            end else if (take && (idx[CNT_W-1:POS_W] == BYTE_NUM)) begin
               byte_q[idx[POS_W-1:0]] <= cur_bit;
            end
         end

         assign cap_flat[k*BYTE_W +: BYTE_W] = byte_q;
      end
   endgenerate

endmodule

// File: rtl/cs_rate_map.sv
module cs_rate_map
   import cs_rate_pkg::*;
#(
   parameter int BYTE_W = CS_BYTE_W,
   parameter int RATE_W = CS_RATE_W
)(
   input  logic [BYTE_W-1:0] byte0,
   input  logic [BYTE_W-1:0] byte3,
   input  logic [BYTE_W-1:0] byte4,
   output logic [RATE_W-1:0] rate
);

   cs_fmt_e    fmt;
   logic [1:0] pro_field;
   logic [3:0] pro_ext;
   logic       unused_bits;

   assign fmt       = cs_fmt_e'(byte0[0]);
   assign pro_field = byte0[7:6];
   assign pro_ext   = byte4[6:3];
   assign unused_bits = ^{byte0[5:1], byte3[BYTE_W-1:4], byte4[BYTE_W-1:7], byte4[2:0]};

   always_comb begin
      rate = RATE_NONE;
      if (fmt == FMT_CONSUMER) begin
         rate = byte3[RATE_W-1:0];
      end else begin
         unique case (pro_field)
            2'b00: begin
               case (pro_ext)
                  4'b1010: rate = RATE_88K2;
                  4'b0010: rate = RATE_96K;
                  default: rate = RATE_NONE;
               endcase
            end
            2'b01: rate = (pro_ext == 4'b0000) ? RATE_44K1 : RATE_NONE;
            2'b10: rate = (pro_ext == 4'b0000) ? RATE_48K  : RATE_NONE;
            2'b11: rate = (pro_ext == 4'b0000) ? RATE_32K  : RATE_NONE;
         endcase
      end
   end

endmodule

// File: rtl/cs_emph_map.sv
module cs_emph_map
   import cs_rate_pkg::*;
#(
   parameter int BYTE_W = CS_BYTE_W
)(
   input  logic [BYTE_W-1:0] byte0,
   output logic              emph
);

   logic pro_on;
   logic con_on;
   logic unused_bits;

   assign pro_on = byte0[2] & ~byte0[3] & ~byte0[4];
   assign con_on = byte0[3] & ~byte0[4] & ~byte0[5];
   assign emph   = (cs_fmt_e'(byte0[0]) == FMT_PRO) ? pro_on : con_on;
   assign unused_bits = ^{byte0[BYTE_W-1:6], byte0[1]};

endmodule

// File: rtl/cs_rate_emph_decoder.sv
module cs_rate_emph_decoder
   import cs_rate_pkg::*;
#(
   parameter int BYTE_W    = CS_BYTE_W,
   parameter int RATE_W    = CS_RATE_W,
   parameter int LAST_BYTE = CS_LAST_BYTE
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              blk_start,
   input  logic              cs_bit_ch1,
   input  logic              cs_bit_ch2,
   input  logic              ch_sel,
   output logic [RATE_W-1:0] rate_code,
   output logic              emph_on
);

   localparam int CAP_W = CS_NCAP * BYTE_W;

   generate
      if (BYTE_W != 8) begin : g_chk_byte
         $error("cs_rate_emph_decoder: field positions need BYTE_W of 8");
      end
      if (RATE_W != 4) begin : g_chk_rate
         $error("cs_rate_emph_decoder: rate codes are 4 bits wide");
      end
      if (LAST_BYTE < 4) begin : g_chk_last
         $error("cs_rate_emph_decoder: capture must reach byte 4");
      end
   endgenerate

   logic [CAP_W-1:0]  cap_flat;
   logic              cap_done;
   logic [RATE_W-1:0] rate_next;
   logic              emph_next;

   cs_stream_capture #(
      .BYTE_W    (BYTE_W),
      .LAST_BYTE (LAST_BYTE),
      .NCAP      (CS_NCAP)
   ) i_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .blk_start (blk_start),
      .bit_ch1   (cs_bit_ch1),
      .bit_ch2   (cs_bit_ch2),
      .ch_sel    (ch_sel),
      .cap_flat  (cap_flat),
      .cap_done  (cap_done)
   );

   cs_rate_map #(
      .BYTE_W (BYTE_W),
      .RATE_W (RATE_W)
   ) i_rate_map (
      .byte0 (cap_flat[0*BYTE_W +: BYTE_W]),
      .byte3 (cap_flat[1*BYTE_W +: BYTE_W]),
      .byte4 (cap_flat[2*BYTE_W +: BYTE_W]),
      .rate  (rate_next)
   );

   cs_emph_map #(
      .BYTE_W (BYTE_W)
   ) i_emph_map (
      .byte0 (cap_flat[0*BYTE_W +: BYTE_W]),
      .emph  (emph_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_code <= RATE_NONE;
         emph_on   <= 1'b0;
      end else if (cap_done) begin
         rate_code <= rate_next;
         emph_on   <= emph_next;
      end
   end

endmodule

// File: rtl/cs_rate_emph_checker.sv
module cs_rate_emph_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        cap_done,
   input logic [23:0] cap_flat,
   input logic [3:0]  rate_code,
   input logic        emph_on
);

   AST_RESET_STATE: assert property (@(posedge clk)
      !rst_n |=> (rate_code == 4'b0001 && !emph_on)); // R1

   AST_CON_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_done && !cap_flat[0]) |=> (rate_code == $past(cap_flat[11:8]))); // R2

   AST_PRO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_done && cap_flat[0]) |=> (rate_code inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b1000, 4'b1010})); // R3

   AST_PRO_EXT_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_done && cap_flat[0] && cap_flat[7:6] != 2'b00 && cap_flat[22:19] != 4'b0000)
      |=> (rate_code == 4'b0001)); // R4

   AST_PRO_EMPH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_done && cap_flat[0] && cap_flat[3]) |=> !emph_on); // R5

   AST_CON_EMPH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_done && !cap_flat[0] && cap_flat[4]) |=> !emph_on); // R6

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_done |=> ($stable(rate_code) && $stable(emph_on))); // R8

   logic unused_bits;
   assign unused_bits = ^{cap_flat[23], cap_flat[18:12], cap_flat[5], cap_flat[2:1]};

endmodule

bind cs_rate_emph_decoder cs_rate_emph_checker i_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cap_done  (cap_done),
   .cap_flat  (cap_flat),
   .rate_code (rate_code),
   .emph_on   (emph_on)
);

// File: tb/test_cs_rate_emph_decoder.sv
module test_cs_rate_emph_decoder;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       blk_start = 1'b0;
   logic       cs_bit_ch1 = 1'b0;
   logic       cs_bit_ch2 = 1'b0;
   logic       ch_sel = 1'b0;
   logic [3:0] rate_code;
   logic       emph_on;

   int vectors = 0;
   int miscompares = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cs_rate_emph_decoder i_cs_rate_emph_decoder (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .blk_start  (blk_start),
      .cs_bit_ch1 (cs_bit_ch1),
      .cs_bit_ch2 (cs_bit_ch2),
      .ch_sel     (ch_sel),
      .rate_code  (rate_code),
      .emph_on    (emph_on)
   );

   function automatic logic [3:0] exp_rate(input logic [7:0] b0, input logic [7:0] b3, input logic [7:0] b4);
      logic [3:0] ext;
      ext = b4[6:3];
      if (!b0[0]) return b3[3:0];
      if (b0[7:6] == 2'b00) begin
         if (ext == 4'd10) return 4'd8;
         if (ext == 4'd2)  return 4'd10;
         return 4'd1;
      end
      if (ext != 4'd0) return 4'd1;
      return (b0[7:6] == 2'b01) ? 4'd0 : {2'b00, b0[7:6]};
   endfunction

   function automatic logic exp_emph(input logic [7:0] b0);
      if (b0[0]) return (b0[4:2] == 3'b001);
      return (b0[5:3] == 3'b001);
   endfunction

   task automatic check(input string req, input logic [3:0] er, input logic ee);
      vectors++;
      if (rate_code !== er || emph_on !== ee) begin
         miscompares++;
         $display("FAIL %s: rate=%b emph=%b expected rate=%b emph=%b", req, rate_code, emph_on, er, ee);
      end
   endtask

   // drives nbits of a block; channel 1 carries a*, channel 2 carries c*
   task automatic send_block(input logic [7:0] a0, input logic [7:0] a3, input logic [7:0] a4,
                             input logic [7:0] c0, input logic [7:0] c3, input logic [7:0] c4,
                             input logic sel, input int flip_at, input bit gaps, input int nbits);
      logic [39:0] sa, sc;
      sa = {a4, a3, 8'h5A, 8'hC3, a0};
      sc = {c4, c3, 8'h3C, 8'hA5, c0};
      for (int i = 0; i < nbits; i++) begin
         if (gaps) begin
            @(negedge clk);
            bit_en = 1'b0;
            blk_start = 1'b1;
            cs_bit_ch1 = 1'($urandom);
            cs_bit_ch2 = 1'($urandom);
            ch_sel = ~sel;
         end
         @(negedge clk);
         bit_en = 1'b1;
         blk_start = (i == 0);
         ch_sel = (flip_at >= 0 && i >= flip_at) ? ~sel : sel;
         cs_bit_ch1 = sa[i];
         cs_bit_ch2 = sc[i];
      end
      @(negedge clk);
      bit_en = 1'b0;
      blk_start = 1'b0;
   endtask

   task automatic run_one(input logic [7:0] b0, input logic [7:0] b3, input logic [7:0] b4, input string req);
      send_block(b0, b3, b4, ~b0, ~b3, ~b4, 1'b0, -1, 1'b0, 40);
      @(negedge clk);
      check(req, exp_rate(b0, b3, b4), exp_emph(b0));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [7:0] b0, b3, b4;
      repeat (3) @(negedge clk);
      check("R1 in reset", 4'b0001, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 after reset", 4'b0001, 1'b0);

      // R8: a block cut short leaves the outputs alone
      send_block(8'h08, 8'h07, 8'h00, 8'h08, 8'h07, 8'h00, 1'b0, -1, 1'b0, 30);
      repeat (3) @(negedge clk);
      check("R8 short block", 4'b0001, 1'b0);

      // R2/R6: consumer rate copy against every emphasis field value
      for (int r = 0; r < 32; r++) begin
         b3 = {4'(r * 7), 4'(r)};
         b0 = {2'(r), 3'(r >> 2), 2'b10, 1'b0};
         b4 = 8'(r * 37 + 5);
         run_one(b0, b3, b4, "R2 R6 consumer");
      end

      // R3/R4/R5: professional rate field x extension, emphasis field rotating
      for (int f = 0; f < 4; f++) begin
         for (int x = 0; x < 16; x++) begin
            b0 = {2'(f), 1'(x), 3'(f * 16 + x), 1'b1, 1'b1};
            b4 = {1'b1, 4'(x), 3'b101};
            b3 = 8'(f * 16 + x + 9);
            run_one(b0, b3, b4, "R3 R4 R5 professional");
         end
      end

      // R7: channel 2 selected for the whole block
      send_block(8'h00, 8'h03, 8'h00, 8'h08, 8'h0C, 8'h00, 1'b1, -1, 1'b0, 40);
      @(negedge clk);
      check("R7 select ch2", 4'hC, 1'b1);
      send_block(8'h08, 8'h06, 8'h00, 8'h00, 8'h0E, 8'h00, 1'b0, -1, 1'b0, 40);
      @(negedge clk);
      check("R7 select ch1", 4'h6, 1'b1);

      // R7: select flipped inside the block is ignored
      send_block(8'h00, 8'h09, 8'h00, 8'h08, 8'h04, 8'h00, 1'b0, 12, 1'b0, 40);
      @(negedge clk);
      check("R7 mid flip to ch2", 4'h9, 1'b0);
      send_block(8'h00, 8'h09, 8'h00, 8'h08, 8'h04, 8'h00, 1'b1, 20, 1'b0, 40);
      @(negedge clk);
      check("R7 mid flip to ch1", 4'h4, 1'b1);

      // R9: idle cycles with junk data and stray start strobes
      send_block(8'h41, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h00, 1'b0, -1, 1'b1, 40);
      @(negedge clk);
      check("R9 idle cycles", 4'b0000, 1'b0);
      send_block(8'h05, 8'hFF, 8'h50, 8'h00, 8'h0F, 8'h00, 1'b0, -1, 1'b1, 40);
      @(negedge clk);
      check("R9 idle cycles pro", 4'b1000, 1'b1);

      // R10: restart in the middle of a block
      send_block(8'h08, 8'h0B, 8'h00, 8'h08, 8'h0B, 8'h00, 1'b1, -1, 1'b0, 20);
      send_block(8'h01, 8'h00, 8'h10, 8'h00, 8'h0D, 8'h00, 1'b0, -1, 1'b0, 40);
      @(negedge clk);
      check("R10 restart", 4'b1010, 1'b0);

      // R8: exact load edge, old values held one cycle after the last bit
      send_block(8'h08, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, -1, 1'b0, 40);
      check("R8 before load", 4'b1010, 1'b0);
      @(negedge clk);
      check("R8 after load", 4'h5, 1'b1);
      repeat (5) @(negedge clk);
      check("R8 hold", 4'h5, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule